// File: doc/BRIEF.md
# Host Opcode Register Dispatcher

This block sits after a host command decoder and turns its command words into the configuration bank of a radar signal-processing chain. Each command is a single-cycle strobe carrying an 8-bit opcode, an 8-bit address byte and a 16-bit value. The opcode selects one target register. The value is cut down to that register's width and written on the next clock edge. The registers then hold their contents until another command addresses them or a reset occurs.

A few opcodes follow rules beyond a plain write. One opcode fires a trigger that lasts a single clock. The stream-control register keeps only its low bits and reads back zero in the bits that are reserved. The chirps-per-elevation field is checked against a fixed frame size: values that are out of range are replaced by the frame size, and any value other than the frame size raises a mismatch flag. That flag clears again when a later write supplies exactly the frame size. All outputs come straight from registers, so downstream logic sees steady values.

Top module: `cmd_cfg_bank`

## Requirements
- R1: Opcode 0x01 loads `mode_o` from value bits [1:0]; code 2 is single-chirp operation.
- R2: Opcode 0x02 drives `trigger_o` high in the cycle after the strobe edge, for exactly one clock per command; at all other times it is low.
- R3: The 16-bit registers are loaded with the full value by these opcodes: 0x03 for `det_thresh_o`, 0x10 for `long_cyc_o`, 0x17 for `med_chirp_cyc_o` and 0x18 for `med_listen_cyc_o`.
- R4: Opcode 0x04 loads `stream_ctl_o` bits [2:0] from value bits [2:0]; bits [5:3] always read zero.
- R5: Opcode 0x15 compares the whole 16-bit value with the frame size of 48. A value of exactly 48 stores 48 and clears `chirp_err_o`. A value of 0, or any value above 48, stores 48 and sets `chirp_err_o`. A value from 1 to 47 is stored unchanged and sets `chirp_err_o`. The flag changes only on this opcode.
- R6: Opcode 0x20 stores value bits [1:0] in `range_mode_o` for all four codes, including the reserved code 2.
- R7: Detection-window opcodes keep the low bits of the value: 0x21 sets guard cells (4 bits), 0x22 training cells (5 bits), 0x23 the Q4.4 scale (8 bits), 0x24 the window mode (2 bits; 1 is greatest-of, 2 is smallest-of) and 0x25 the enable (bit 0).
- R8: Opcode 0x2D loads the 8-bit soft scale `cfar_alpha_soft_o` from value bits [7:0].
- R9: The address byte has no effect on any write. A strobe carrying an opcode outside the listed set changes no output.
- R10: A write becomes visible on the first clock edge after the strobe cycle. While the strobe is low, every register holds its value, whatever the opcode and value inputs carry.
- R11: While `rst` is high (synchronous), the outputs take these values: mode 0, threshold 1000, stream 1, long cycles 3000, medium chirp 500, medium listen 20000, chirps 48, flag clear, range 0, guard 2, training 8, scale 0x30, window mode 0, enable 0, soft scale 0x20, trigger low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | One-cycle strobe marking a command |
| cmd_opcode | input | 8 | Command opcode |
| cmd_addr | input | 8 | Address byte, not used by any opcode |
| cmd_value | input | 16 | Command value |
| trigger_o | output | 1 | Single-cycle trigger pulse |
| mode_o | output | 2 | Operating mode |
| det_thresh_o | output | 16 | Detection threshold |
| stream_ctl_o | output | 6 | Stream enables, upper bits reserved |
| long_cyc_o | output | 16 | Long-chirp cycle count |
| med_chirp_cyc_o | output | 16 | Medium-chirp cycle count |
| med_listen_cyc_o | output | 16 | Medium listen cycle count |
| chirps_elev_o | output | 6 | Chirps per elevation step |
| chirp_err_o | output | 1 | Chirp-count mismatch flag |
| range_mode_o | output | 2 | Range mode |
| cfar_guard_o | output | 4 | Guard cells |
| cfar_train_o | output | 5 | Training cells |
| cfar_alpha_o | output | 8 | Threshold scale, Q4.4 |
| cfar_mode_o | output | 2 | Window combining mode |
| cfar_en_o | output | 1 | Detector enable |
| cfar_alpha_soft_o | output | 8 | Soft threshold scale |

## Verification
The bench uses the default parameters: a frame size of 48, a 6-bit chirp field and a 6-bit stream register with 3 live bits. With these values, every branch of the chirp guard can be reached with small values: exactly 48, zero, 47, 1, and 56. It also covers 0x0100, which is above the limit but has its low six bits all zero, so it only gives the right result if the compare uses all 16 value bits. Values with high bits set, such as 0xFFFD or 0x1210, show that narrow registers keep only their own slice of the value.

// File: rtl/cfg_bank_pkg.sv
`timescale 1ns/1ps
package cfg_bank_pkg;

    localparam int VAL_W    = 16;
    localparam int OPC_W    = 8;
    localparam int MODE_W   = 2;
    localparam int RANGE_W  = 2;
    localparam int GUARD_W  = 4;
    localparam int TRAIN_W  = 5;
    localparam int ALPHA_W  = 8;
    localparam int WMODE_W  = 2;
    localparam int N_WIDE   = 4;

    localparam logic [OPC_W-1:0] OPC_MODE   = 8'h01;
    localparam logic [OPC_W-1:0] OPC_TRIG   = 8'h02;
    localparam logic [OPC_W-1:0] OPC_THRESH = 8'h03;
    localparam logic [OPC_W-1:0] OPC_STREAM = 8'h04;
    localparam logic [OPC_W-1:0] OPC_LONG   = 8'h10;
    localparam logic [OPC_W-1:0] OPC_CHIRPS = 8'h15;
    localparam logic [OPC_W-1:0] OPC_MEDC   = 8'h17;
    localparam logic [OPC_W-1:0] OPC_MEDL   = 8'h18;
    localparam logic [OPC_W-1:0] OPC_RANGE  = 8'h20;
    localparam logic [OPC_W-1:0] OPC_GUARD  = 8'h21;
    localparam logic [OPC_W-1:0] OPC_TRAIN  = 8'h22;
    localparam logic [OPC_W-1:0] OPC_ALPHA  = 8'h23;
    localparam logic [OPC_W-1:0] OPC_WMODE  = 8'h24;
    localparam logic [OPC_W-1:0] OPC_DETEN  = 8'h25;
    localparam logic [OPC_W-1:0] OPC_SOFT   = 8'h2D;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_MODE, SEL_TRIG, SEL_THRESH, SEL_STREAM, SEL_LONG,
        SEL_MEDC, SEL_MEDL, SEL_CHIRPS, SEL_RANGE, SEL_GUARD, SEL_TRAIN,
        SEL_ALPHA, SEL_WMODE, SEL_DETEN, SEL_SOFT
    } sel_e;

    typedef struct packed {
        logic [OPC_W-1:0] op;
        logic [OPC_W-1:0] addr;
        logic [VAL_W-1:0] value;
    } cmd_t;

    // reset values
    localparam logic [MODE_W-1:0]  RST_MODE  = 2'd0;
    localparam logic [RANGE_W-1:0] RST_RANGE = 2'd0;
    localparam logic [GUARD_W-1:0] RST_GUARD = 4'd2;
    localparam logic [TRAIN_W-1:0] RST_TRAIN = 5'd8;
    localparam logic [ALPHA_W-1:0] RST_ALPHA = 8'h30;
    localparam logic [WMODE_W-1:0] RST_WMODE = 2'd0;
    localparam logic [ALPHA_W-1:0] RST_SOFT  = 8'h20;

    function automatic sel_e op_to_sel(input logic [OPC_W-1:0] op);
        case (op)
            OPC_MODE:   return SEL_MODE;
            OPC_TRIG:   return SEL_TRIG;
            OPC_THRESH: return SEL_THRESH;
            OPC_STREAM: return SEL_STREAM;
            OPC_LONG:   return SEL_LONG;
            OPC_CHIRPS: return SEL_CHIRPS;
            OPC_MEDC:   return SEL_MEDC;
            OPC_MEDL:   return SEL_MEDL;
            OPC_RANGE:  return SEL_RANGE;
            OPC_GUARD:  return SEL_GUARD;
            OPC_TRAIN:  return SEL_TRAIN;
            OPC_ALPHA:  return SEL_ALPHA;
            OPC_WMODE:  return SEL_WMODE;
            OPC_DETEN:  return SEL_DETEN;
            OPC_SOFT:   return SEL_SOFT;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic op_known(input logic [OPC_W-1:0] op);
        return op_to_sel(op) != SEL_NONE;
    endfunction

    // slot map of the full-width registers: 0 thresh, 1 long, 2 med chirp, 3 med listen
    function automatic sel_e wide_slot_sel(input int idx);
        case (idx)
            0:       return SEL_THRESH;
            1:       return SEL_LONG;
            2:       return SEL_MEDC;
            default: return SEL_MEDL;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] wide_slot_init(input int idx);
        case (idx)
            0:       return 16'd1000;
            1:       return 16'd3000;
            2:       return 16'd500;
            default: return 16'd20000;
        endcase
    endfunction

endpackage

// File: rtl/cfg_op_decode.sv
`timescale 1ns/1ps
module cfg_op_decode
    import cfg_bank_pkg::*;
(
    input  logic             valid,
    input  logic [OPC_W-1:0] op,
    output sel_e             sel
);
    always_comb begin
        sel = SEL_NONE;
        if (valid) sel = op_to_sel(op);
    end
endmodule

// File: rtl/cfg_chirp_guard.sv
`timescale 1ns/1ps
module cfg_chirp_guard #(
    parameter int FRAME_CHIRPS = 48,
    parameter int CHIRP_W      = 6,
    parameter int IN_W         = 16
) (
    input  logic [IN_W-1:0]    value,
    output logic [CHIRP_W-1:0] chirps,
    output logic               mismatch
);
    localparam logic [IN_W-1:0]    FRAME_IN = IN_W'(FRAME_CHIRPS);
    localparam logic [CHIRP_W-1:0] FRAME_CH = CHIRP_W'(FRAME_CHIRPS);

    logic is_exact;
    logic out_of_range;

    always_comb begin
        is_exact     = (value == FRAME_IN);
        out_of_range = (value == '0) || (value > FRAME_IN);
        mismatch     = !is_exact;
        if (is_exact || out_of_range) chirps = FRAME_CH;
        else                          chirps = value[CHIRP_W-1:0];
    end
endmodule

// File: rtl/cfg_field_reg.sv
`timescale 1ns/1ps
module cfg_field_reg #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= INIT;
        else if (we) q <= d;
    end
endmodule

// File: rtl/cmd_cfg_bank.sv
`timescale 1ns/1ps
module cmd_cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int FRAME_CHIRPS = 48,
    parameter int CHIRP_W      = 6,
    parameter int STREAM_W     = 6,
    parameter int STREAM_LIVE  = 3,
    parameter int STREAM_INIT  = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_opcode,
    input  logic [7:0]          cmd_addr,
    input  logic [15:0]         cmd_value,
    output logic                trigger_o,
    output logic [1:0]          mode_o,
    output logic [15:0]         det_thresh_o,
    output logic [STREAM_W-1:0] stream_ctl_o,
    output logic [15:0]         long_cyc_o,
    output logic [15:0]         med_chirp_cyc_o,
    output logic [15:0]         med_listen_cyc_o,
    output logic [CHIRP_W-1:0]  chirps_elev_o,
    output logic                chirp_err_o,
    output logic [1:0]          range_mode_o,
    output logic [3:0]          cfar_guard_o,
    output logic [4:0]          cfar_train_o,
    output logic [7:0]          cfar_alpha_o,
    output logic [1:0]          cfar_mode_o,
    output logic                cfar_en_o,
    output logic [7:0]          cfar_alpha_soft_o
);
    localparam int RSV_W = STREAM_W - STREAM_LIVE;
    localparam logic [CHIRP_W-1:0]  CHIRP_RST  = CHIRP_W'(FRAME_CHIRPS);
    localparam logic [STREAM_W-1:0] STREAM_RST = STREAM_W'(STREAM_INIT);

    cmd_t cmd;
    sel_e sel;
    logic unused_addr_bits;

    assign cmd = '{op: cmd_opcode, addr: cmd_addr, value: cmd_value};
    assign unused_addr_bits = ^cmd.addr;

    cfg_op_decode u_dec (
        .valid (cmd_valid),
        .op    (cmd.op),
        .sel   (sel)
    );

    // single-cycle trigger
    logic trig_q;
    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= (sel == SEL_TRIG);
    end
    assign trigger_o = trig_q;

    // full-width cycle / threshold registers
    logic [VAL_W-1:0] wide_q [N_WIDE];
    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        cfg_field_reg #(.W(VAL_W), .INIT(wide_slot_init(g))) u_reg (
            .clk (clk),
            .rst (rst),
            .we  (sel == wide_slot_sel(g)),
            .d   (cmd.value),
            .q   (wide_q[g])
        );
    end
    assign det_thresh_o     = wide_q[0];
    assign long_cyc_o       = wide_q[1];
    assign med_chirp_cyc_o  = wide_q[2];
    assign med_listen_cyc_o = wide_q[3];

    // stream control with reserved upper bits
    logic [STREAM_W-1:0] stream_d;
    assign stream_d = {{RSV_W{1'b0}}, cmd.value[STREAM_LIVE-1:0]};
    cfg_field_reg #(.W(STREAM_W), .INIT(STREAM_RST)) u_stream (
        .clk (clk), .rst (rst), .we (sel == SEL_STREAM),
        .d (stream_d), .q (stream_ctl_o)
    );

    // chirps per elevation with range guard
    logic [CHIRP_W-1:0] chirp_d;
    logic               chirp_mis;
    cfg_chirp_guard #(
        .FRAME_CHIRPS (FRAME_CHIRPS),
        .CHIRP_W      (CHIRP_W),
        .IN_W         (VAL_W)
    ) u_guard (
        .value    (cmd.value),
        .chirps   (chirp_d),
        .mismatch (chirp_mis)
    );
    cfg_field_reg #(.W(CHIRP_W), .INIT(CHIRP_RST)) u_chirps (
        .clk (clk), .rst (rst), .we (sel == SEL_CHIRPS),
        .d (chirp_d), .q (chirps_elev_o)
    );
    cfg_field_reg #(.W(1), .INIT(1'b0)) u_chirp_err (
        .clk (clk), .rst (rst), .we (sel == SEL_CHIRPS),
        .d (chirp_mis), .q (chirp_err_o)
    );

    // narrow fields, truncated from the value
    cfg_field_reg #(.W(MODE_W), .INIT(RST_MODE)) u_mode (
        .clk (clk), .rst (rst), .we (sel == SEL_MODE),
        .d (cmd.value[MODE_W-1:0]), .q (mode_o)
    );
    cfg_field_reg #(.W(RANGE_W), .INIT(RST_RANGE)) u_range (
        .clk (clk), .rst (rst), .we (sel == SEL_RANGE),
        .d (cmd.value[RANGE_W-1:0]), .q (range_mode_o)
    );
    cfg_field_reg #(.W(GUARD_W), .INIT(RST_GUARD)) u_guard_cells (
        .clk (clk), .rst (rst), .we (sel == SEL_GUARD),
        .d (cmd.value[GUARD_W-1:0]), .q (cfar_guard_o)
    );
    cfg_field_reg #(.W(TRAIN_W), .INIT(RST_TRAIN)) u_train (
        .clk (clk), .rst (rst), .we (sel == SEL_TRAIN),
        .d (cmd.value[TRAIN_W-1:0]), .q (cfar_train_o)
    );
    cfg_field_reg #(.W(ALPHA_W), .INIT(RST_ALPHA)) u_alpha (
        .clk (clk), .rst (rst), .we (sel == SEL_ALPHA),
        .d (cmd.value[ALPHA_W-1:0]), .q (cfar_alpha_o)
    );
    cfg_field_reg #(.W(WMODE_W), .INIT(RST_WMODE)) u_wmode (
        .clk (clk), .rst (rst), .we (sel == SEL_WMODE),
        .d (cmd.value[WMODE_W-1:0]), .q (cfar_mode_o)
    );
    cfg_field_reg #(.W(1), .INIT(1'b0)) u_deten (
        .clk (clk), .rst (rst), .we (sel == SEL_DETEN),
        .d (cmd.value[0]), .q (cfar_en_o)
    );
    cfg_field_reg #(.W(ALPHA_W), .INIT(RST_SOFT)) u_soft (
        .clk (clk), .rst (rst), .we (sel == SEL_SOFT),
        .d (cmd.value[ALPHA_W-1:0]), .q (cfar_alpha_soft_o)
    );

endmodule

// File: rtl/cmd_cfg_bank_chk.sv
`timescale 1ns/1ps
module cmd_cfg_bank_chk
    import cfg_bank_pkg::*;
#(
    parameter int FRAME_CHIRPS = 48,
    parameter int CHIRP_W      = 6,
    parameter int STREAM_W     = 6,
    parameter int STREAM_LIVE  = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic [7:0]          cmd_opcode,
    input logic [15:0]         cmd_value,
    input logic                trigger_o,
    input logic [1:0]          mode_o,
    input logic [15:0]         det_thresh_o,
    input logic [STREAM_W-1:0] stream_ctl_o,
    input logic [15:0]         long_cyc_o,
    input logic [15:0]         med_chirp_cyc_o,
    input logic [15:0]         med_listen_cyc_o,
    input logic [CHIRP_W-1:0]  chirps_elev_o,
    input logic                chirp_err_o,
    input logic [1:0]          range_mode_o,
    input logic [3:0]          cfar_guard_o,
    input logic [4:0]          cfar_train_o,
    input logic [7:0]          cfar_alpha_o,
    input logic [1:0]          cfar_mode_o,
    input logic                cfar_en_o,
    input logic [7:0]          cfar_alpha_soft_o
);
    localparam logic [CHIRP_W-1:0] FRAME_CH = CHIRP_W'(FRAME_CHIRPS);

    logic [119:0] bank;
    assign bank = {mode_o, det_thresh_o, 10'(stream_ctl_o), long_cyc_o,
                   med_chirp_cyc_o, med_listen_cyc_o, 8'(chirps_elev_o),
                   chirp_err_o, range_mode_o, cfar_guard_o, cfar_train_o,
                   cfar_alpha_o, cfar_mode_o, cfar_en_o, cfar_alpha_soft_o,
                   8'h00};

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_opcode == OPC_MODE) |=> (mode_o == $past(cmd_value[1:0])))
        else $error("mode write lost"); // R1

    AST_TRIG_SOURCE: assert property (@(posedge clk) disable iff (rst)
        trigger_o |-> $past(cmd_valid && cmd_opcode == OPC_TRIG))
        else $error("trigger without command"); // R2

    AST_TRIG_FIRES: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_opcode == OPC_TRIG) |=> trigger_o)
        else $error("trigger missing"); // R2

    AST_STREAM_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        stream_ctl_o[STREAM_W-1:STREAM_LIVE] == '0)
        else $error("reserved stream bits set"); // R4

    AST_CHIRP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (chirps_elev_o != '0) && (chirps_elev_o <= FRAME_CH))
        else $error("chirp field out of range"); // R5

    AST_CHIRP_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !chirp_err_o |-> (chirps_elev_o == FRAME_CH))
        else $error("flag clear on mismatched count"); // R5

    AST_UNKNOWN_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !op_known(cmd_opcode)) |=> $stable(bank))
        else $error("unknown opcode changed state"); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(bank))
        else $error("register moved without strobe"); // R10

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (chirps_elev_o == FRAME_CH && !chirp_err_o && !cfar_en_o && !trigger_o))
        else $error("reset state wrong"); // R11
endmodule

bind cmd_cfg_bank cmd_cfg_bank_chk #(
    .FRAME_CHIRPS (FRAME_CHIRPS),
    .CHIRP_W      (CHIRP_W),
    .STREAM_W     (STREAM_W),
    .STREAM_LIVE  (STREAM_LIVE)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .cmd_valid         (cmd_valid),
    .cmd_opcode        (cmd_opcode),
    .cmd_value         (cmd_value),
    .trigger_o         (trigger_o),
    .mode_o            (mode_o),
    .det_thresh_o      (det_thresh_o),
    .stream_ctl_o      (stream_ctl_o),
    .long_cyc_o        (long_cyc_o),
    .med_chirp_cyc_o   (med_chirp_cyc_o),
    .med_listen_cyc_o  (med_listen_cyc_o),
    .chirps_elev_o     (chirps_elev_o),
    .chirp_err_o       (chirp_err_o),
    .range_mode_o      (range_mode_o),
    .cfar_guard_o      (cfar_guard_o),
    .cfar_train_o      (cfar_train_o),
    .cfar_alpha_o      (cfar_alpha_o),
    .cfar_mode_o       (cfar_mode_o),
    .cfar_en_o         (cfar_en_o),
    .cfar_alpha_soft_o (cfar_alpha_soft_o)
);

// File: tb/sim_cmd_cfg_bank.sv
`timescale 1ns/1ps
module sim_cmd_cfg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 39;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = 8'h00;
    logic [7:0]  cmd_addr = 8'h00;
    logic [15:0] cmd_value = 16'h0000;

    logic        trigger_o;
    logic [1:0]  mode_o;
    logic [15:0] det_thresh_o;
    logic [5:0]  stream_ctl_o;
    logic [15:0] long_cyc_o;
    logic [15:0] med_chirp_cyc_o;
    logic [15:0] med_listen_cyc_o;
    logic [5:0]  chirps_elev_o;
    logic        chirp_err_o;
    logic [1:0]  range_mode_o;
    logic [3:0]  cfar_guard_o;
    logic [4:0]  cfar_train_o;
    logic [7:0]  cfar_alpha_o;
    logic [1:0]  cfar_mode_o;
    logic        cfar_en_o;
    logic [7:0]  cfar_alpha_soft_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_cfg_bank u0 (
        .clk (clk), .rst (rst), .cmd_valid (cmd_valid),
        .cmd_opcode (cmd_opcode), .cmd_addr (cmd_addr), .cmd_value (cmd_value),
        .trigger_o (trigger_o), .mode_o (mode_o), .det_thresh_o (det_thresh_o),
        .stream_ctl_o (stream_ctl_o), .long_cyc_o (long_cyc_o),
        .med_chirp_cyc_o (med_chirp_cyc_o), .med_listen_cyc_o (med_listen_cyc_o),
        .chirps_elev_o (chirps_elev_o), .chirp_err_o (chirp_err_o),
        .range_mode_o (range_mode_o), .cfar_guard_o (cfar_guard_o),
        .cfar_train_o (cfar_train_o), .cfar_alpha_o (cfar_alpha_o),
        .cfar_mode_o (cfar_mode_o), .cfar_en_o (cfar_en_o),
        .cfar_alpha_soft_o (cfar_alpha_soft_o)
    );

    // {opcode, addr, value, output select, requirement, expected}
    localparam logic [63:0] VEC [0:NV-1] = '{
        {8'h01, 8'h00, 16'h0002, 8'd0,  8'd1, 16'h0002},  // R1 single chirp
        {8'h01, 8'h00, 16'hFFFD, 8'd0,  8'd1, 16'h0001},  // R1 truncation
        {8'h03, 8'h00, 16'h1234, 8'd1,  8'd3, 16'h1234},  // R3
        {8'h10, 8'h00, 16'h07D0, 8'd3,  8'd3, 16'h07D0},  // R3
        {8'h17, 8'h00, 16'h02EE, 8'd4,  8'd3, 16'h02EE},  // R3
        {8'h18, 8'h00, 16'h4074, 8'd5,  8'd3, 16'h4074},  // R3
        {8'h04, 8'h00, 16'h0005, 8'd2,  8'd4, 16'h0005},  // R4
        {8'h04, 8'h00, 16'h00FF, 8'd2,  8'd4, 16'h0007},  // R4 reserved bits
        {8'h15, 8'h00, 16'h0030, 8'd6,  8'd5, 16'h0030},  // R5 exact
        {8'h15, 8'h00, 16'h0030, 8'd7,  8'd5, 16'h0000},  // R5
        {8'h15, 8'h00, 16'h0038, 8'd6,  8'd5, 16'h0030},  // R5 above
        {8'h15, 8'h00, 16'h0038, 8'd7,  8'd5, 16'h0001},  // R5
        {8'h15, 8'h00, 16'h0000, 8'd6,  8'd5, 16'h0030},  // R5 zero
        {8'h15, 8'h00, 16'h0000, 8'd7,  8'd5, 16'h0001},  // R5
        {8'h15, 8'h00, 16'h0010, 8'd6,  8'd5, 16'h0010},  // R5 below
        {8'h15, 8'h00, 16'h0010, 8'd7,  8'd5, 16'h0001},  // R5
        {8'h15, 8'h00, 16'h0100, 8'd6,  8'd5, 16'h0030},  // R5 wide compare
        {8'h15, 8'h00, 16'h002F, 8'd6,  8'd5, 16'h002F},  // R5 edge 47
        {8'h15, 8'h00, 16'h0001, 8'd6,  8'd5, 16'h0001},  // R5 edge 1
        {8'h15, 8'h00, 16'h0030, 8'd7,  8'd5, 16'h0000},  // R5 restore
        {8'h20, 8'h00, 16'h0001, 8'd8,  8'd6, 16'h0001},  // R6
        {8'h20, 8'h00, 16'h0002, 8'd8,  8'd6, 16'h0002},  // R6 reserved code
        {8'h20, 8'h00, 16'h0003, 8'd8,  8'd6, 16'h0003},  // R6
        {8'h20, 8'h00, 16'h0000, 8'd8,  8'd6, 16'h0000},  // R6
        {8'h21, 8'h00, 16'h0004, 8'd9,  8'd7, 16'h0004},  // R7
        {8'h21, 8'h00, 16'h00FF, 8'd9,  8'd7, 16'h000F},  // R7
        {8'h22, 8'h00, 16'h0010, 8'd10, 8'd7, 16'h0010},  // R7
        {8'h22, 8'h00, 16'h0001, 8'd10, 8'd7, 16'h0001},  // R7
        {8'h23, 8'h00, 16'h0048, 8'd11, 8'd7, 16'h0048},  // R7
        {8'h23, 8'h00, 16'h1210, 8'd11, 8'd7, 16'h0010},  // R7
        {8'h24, 8'h00, 16'h0001, 8'd12, 8'd7, 16'h0001},  // R7 greatest-of
        {8'h24, 8'h00, 16'h0002, 8'd12, 8'd7, 16'h0002},  // R7 smallest-of
        {8'h25, 8'h00, 16'h0001, 8'd13, 8'd7, 16'h0001},  // R7
        {8'h25, 8'h00, 16'h0000, 8'd13, 8'd7, 16'h0000},  // R7
        {8'h2D, 8'h00, 16'h0024, 8'd14, 8'd8, 16'h0024},  // R8
        {8'h03, 8'hA5, 16'hBEEF, 8'd1,  8'd9, 16'hBEEF},  // R9 address ignored
        {8'h23, 8'hFF, 16'h0033, 8'd11, 8'd9, 16'h0033},  // R9
        {8'h15, 8'h77, 16'h0010, 8'd6,  8'd9, 16'h0010},  // R9
        {8'h15, 8'h00, 16'h0030, 8'd6,  8'd5, 16'h0030}   // R5
    };

    function automatic logic [15:0] get_out(input int s);
        case (s)
            0:       return 16'(mode_o);
            1:       return det_thresh_o;
            2:       return 16'(stream_ctl_o);
            3:       return long_cyc_o;
            4:       return med_chirp_cyc_o;
            5:       return med_listen_cyc_o;
            6:       return 16'(chirps_elev_o);
            7:       return 16'(chirp_err_o);
            8:       return 16'(range_mode_o);
            9:       return 16'(cfar_guard_o);
            10:      return 16'(cfar_train_o);
            11:      return 16'(cfar_alpha_o);
            12:      return 16'(cfar_mode_o);
            13:      return 16'(cfar_en_o);
            default: return 16'(cfar_alpha_soft_o);
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [7:0] ad, input logic [15:0] v);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = op; cmd_addr = ad; cmd_value = v;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_defaults(input string tag);
        chk(tag, "mode",        get_out(0),  16'd0);
        chk(tag, "threshold",   get_out(1),  16'd1000);
        chk(tag, "stream",      get_out(2),  16'd1);
        chk(tag, "long",        get_out(3),  16'd3000);
        chk(tag, "med chirp",   get_out(4),  16'd500);
        chk(tag, "med listen",  get_out(5),  16'd20000);
        chk(tag, "chirps",      get_out(6),  16'd48);
        chk(tag, "chirp flag",  get_out(7),  16'd0);
        chk(tag, "range",       get_out(8),  16'd0);
        chk(tag, "guard",       get_out(9),  16'd2);
        chk(tag, "train",       get_out(10), 16'd8);
        chk(tag, "alpha",       get_out(11), 16'h30);
        chk(tag, "window mode", get_out(12), 16'd0);
        chk(tag, "enable",      get_out(13), 16'd0);
        chk(tag, "soft alpha",  get_out(14), 16'h20);
        chk(tag, "trigger",     16'(trigger_o), 16'd0);
    endtask

    initial begin
        logic [15:0] snap [15];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_defaults("R11");

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [63:0] e;
            e = VEC[i];
            send(e[63:56], e[55:48], e[47:32]);
            chk($sformatf("R%0d", e[23:16]), $sformatf("vector %0d", i),
                get_out(int'(e[31:24])), e[15:0]);
        end

        // R2: trigger one cycle after strobe, one cycle long
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = 8'h02; cmd_addr = 8'h00; cmd_value = 16'h0000;
        #1 chk("R2", "trigger low in strobe cycle", 16'(trigger_o), 16'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2", "trigger high after edge", 16'(trigger_o), 16'd1);
        @(negedge clk);
        chk("R2", "trigger cleared", 16'(trigger_o), 16'd0);
        @(negedge clk);
        chk("R2", "trigger stays low", 16'(trigger_o), 16'd0);

        // R10: write lands on the edge after the strobe
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = 8'h03; cmd_value = 16'h5555;
        #(CLK_PERIOD/2 - 1);
        chk("R10", "threshold before edge", det_thresh_o, 16'hBEEF);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10", "threshold after edge", det_thresh_o, 16'h5555);
        // R10: inputs change without strobe
        cmd_opcode = 8'h03; cmd_value = 16'h0000;
        repeat (4) @(negedge clk);
        chk("R10", "threshold held without strobe", det_thresh_o, 16'h5555);
        cmd_opcode = 8'h15; cmd_value = 16'h0005;
        @(negedge clk);
        chk("R10", "chirps held without strobe", 16'(chirps_elev_o), 16'd48);

        // R9: unknown opcodes change nothing
        for (int s = 0; s < 15; s++) snap[s] = get_out(s);
        send(8'h05, 8'h00, 16'hFFFF);
        send(8'hFF, 8'h3C, 16'hFFFF);
        send(8'h11, 8'h00, 16'h0001);
        send(8'h2C, 8'h00, 16'h00AA);
        for (int s = 0; s < 15; s++)
            chk("R9", $sformatf("output %0d after unknown opcodes", s), get_out(s), snap[s]);
        chk("R9", "no trigger from unknown", 16'(trigger_o), 16'd0);

        // R5: flag sticks across other writes until exact size written
        send(8'h15, 8'h00, 16'd20);
        send(8'h25, 8'h00, 16'h0001);
        chk("R5", "flag kept across other write", 16'(chirp_err_o), 16'd1);
        send(8'h15, 8'h00, 16'd48);
        chk("R5", "flag cleared by exact size", 16'(chirp_err_o), 16'd0);

        // R11: reset in mid-run restores defaults
        send(8'h15, 8'h00, 16'd7);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_defaults("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule